// File: doc/BRIEF.md
# Eight-Input Key Interrupt Controller

The controller samples eight external key lines and merges them into one shared interrupt request. Each line first passes through a two-stage synchronizer on the system clock. Software then chooses, for each line, whether it takes part and whether its active sense is low/falling or high/rising. A global detect mode selects between two behaviours:

- **Edge only:** only transitions into the active level count.
- **Edge plus level:** transitions count, and so does a line that stays at its active level.

Any detected event sets a sticky flag. The interrupt output is that flag gated by a global request enable. Software clears the flag by writing 1 to a strobe bit. When level detection is selected, that strobe cannot clear the flag while any enabled line still sits at its active level, because the detection sets the flag again in the same cycle.

The register port has three words. Word 0 holds control and status: bit 0 is the detect mode, bit 1 the request enable, bit 2 the clear strobe, and bit 3 the flag. Word 1 holds the line enables and word 2 the line senses.

Top module: `kbi_ctrl`

## Requirements
- R1: Each key line reaches the detector through two synchronizing flops. A change driven after rising edge E0 can set the flag no earlier than edge E3. The flag is visible after E3 and not after E2.
- R2: A line whose enable bit (word 1, bit i) is 0 never sets the flag, whatever it does.
- R3: A sense bit (word 2, bit i) of 0 makes the line active-low and falling-edge sensitive. A sense bit of 1 makes it active-high and rising-edge sensitive. A transition out of the active level sets nothing.
- R4: With the detect mode (word 0, bit 0) at 0, a line held at its active level sets the flag only once. After a clear, the flag stays 0 until a new transition into the active level.
- R5: With the detect mode at 1, an enabled line at its active level sets the flag. A clear strobe has no effect while any enabled line remains active.
- R6: irq_out is 1 exactly when the flag is 1 and the request enable (word 0, bit 1) is 1.
- R7: Writing 1 to word 0, bit 2 clears the flag on that edge, unless an event is detected on the same edge, in which case the flag stays set. Bit 2 always reads 0.
- R8: Changing a line's enable or sense bit does not by itself count as a transition. Only a later transition of the line into its active level sets the flag in edge-only mode.
- R9: After reset, the mode, request enable, line enables, line senses and the flag are all 0.
- R10: The flag (word 0, bit 3) is read-only and ignores writes. Word 1 reads back the line enables, word 2 the line senses, and word 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_in | input | 8 | Asynchronous key lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word written |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Register word read |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| irq_out | output | 1 | Shared interrupt request |

## Verification
Two functions can fall on the same clock edge: a software clear of the flag and a fresh detection that sets it. The bench provokes this by issuing the clear write exactly two edges after driving a key transition, so that the write lands on the detection edge. The result is judged as correct only if the flag stays set. The same collision is also produced in level mode by clearing while a line is held active. A per-cycle behavioural model, built from a history queue of raw key samples, judges every edge of every other sequence.

// File: rtl/kbi_pkg.sv
package kbi_pkg;

    localparam int unsigned ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_EN   = 2'd1,
        REG_POL  = 2'd2,
        REG_NONE = 2'd3
    } kbi_reg_e;

    localparam int unsigned BIT_MODE = 0;
    localparam int unsigned BIT_IE   = 1;
    localparam int unsigned BIT_ACK  = 2;
    localparam int unsigned BIT_FLAG = 3;
    localparam int unsigned CTRL_BITS = 4;

    typedef struct packed {
        logic mode;
        logic ie;
    } kbi_ctrl_t;

endpackage

// File: rtl/kbi_sync.sv
module kbi_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0][N-1:0] stage_d;
    logic [STAGES-1:0][N-1:0] stage_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/kbi_detect.sv
module kbi_detect #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] pol_i,
    input  logic         mode_i,
    output logic         event_o
);
    typedef struct packed {
        logic [N-1:0] hist;
        logic [N-1:0] en_prev;
        logic [N-1:0] pol_prev;
    } det_state_t;

    det_state_t st_d, st_q;

    logic [N-1:0] active;
    logic [N-1:0] cfg_chg;
    logic [N-1:0] edge_hit;
    logic [N-1:0] lvl_hit;

    generate
        for (genvar i = 0; i < N; i++) begin : g_pin
            always_comb begin
                // sense bit 1: active high; 0: active low
                active[i]   = pol_i[i] ? sync_i[i] : ~sync_i[i];
                cfg_chg[i]  = (en_i[i] ^ st_q.en_prev[i]) | (pol_i[i] ^ st_q.pol_prev[i]);
                edge_hit[i] = en_i[i] & active[i] & ~st_q.hist[i] & ~cfg_chg[i];
                lvl_hit[i]  = en_i[i] & active[i] & mode_i;
            end
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.hist     = active;
        st_d.en_prev  = en_i;
        st_d.pol_prev = pol_i;
        event_o       = |(edge_hit | lvl_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/kbi_regs.sv
module kbi_regs
    import kbi_pkg::*;
#(
    parameter int unsigned N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              flag_i,
    output logic [N-1:0]      en_o,
    output logic [N-1:0]      pol_o,
    output logic              mode_o,
    output logic              ie_o,
    output logic              ack_o,
    output logic [N-1:0]      rd_data
);
    typedef struct packed {
        kbi_ctrl_t    ctrl;
        logic [N-1:0] en;
        logic [N-1:0] pol;
    } reg_state_t;

    reg_state_t rs_d, rs_q;

    always_comb begin
        rs_d  = rs_q;
        ack_o = 1'b0;
        if (wr_en) begin
            unique case (kbi_reg_e'(wr_addr))
                REG_CTRL: begin
                    rs_d.ctrl.mode = wr_data[BIT_MODE];
                    rs_d.ctrl.ie   = wr_data[BIT_IE];
                    ack_o          = wr_data[BIT_ACK];
                end
                REG_EN:   rs_d.en  = wr_data;
                REG_POL:  rs_d.pol = wr_data;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (kbi_reg_e'(rd_addr))
            REG_CTRL: begin
                rd_data[BIT_MODE] = rs_q.ctrl.mode;
                rd_data[BIT_IE]   = rs_q.ctrl.ie;
                rd_data[BIT_FLAG] = flag_i;
            end
            REG_EN:   rd_data = rs_q.en;
            REG_POL:  rd_data = rs_q.pol;
            default:  rd_data = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign en_o   = rs_q.en;
    assign pol_o  = rs_q.pol;
    assign mode_o = rs_q.ctrl.mode;
    assign ie_o   = rs_q.ctrl.ie;

endmodule

// File: rtl/kbi_ctrl.sv
module kbi_ctrl
    import kbi_pkg::*;
#(
    parameter int unsigned N           = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      key_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [N-1:0]      rd_data,
    output logic              irq_out
);
    typedef struct packed {
        logic flag;
    } top_state_t;

    top_state_t ts_d, ts_q;

    logic [N-1:0] key_sync;
    logic [N-1:0] en_q;
    logic [N-1:0] pol_q;
    logic         mode_q;
    logic         ie_q;
    logic         ack;
    logic         det_event;

    kbi_sync #(.N(N), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (key_in),
        .sync_o  (key_sync)
    );

    kbi_regs #(.N(N)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .flag_i  (ts_q.flag),
        .en_o    (en_q),
        .pol_o   (pol_q),
        .mode_o  (mode_q),
        .ie_o    (ie_q),
        .ack_o   (ack),
        .rd_data (rd_data)
    );

    kbi_detect #(.N(N)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .sync_i  (key_sync),
        .en_i    (en_q),
        .pol_i   (pol_q),
        .mode_i  (mode_q),
        .event_o (det_event)
    );

    always_comb begin
        ts_d      = ts_q;
        // a detection on the same edge wins over the clear strobe
        ts_d.flag = det_event | (ts_q.flag & ~ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    assign irq_out = ts_q.flag & ie_q;

endmodule

// File: rtl/kbi_ctrl_chk.sv
module kbi_ctrl_chk #(
    parameter int unsigned N = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] en,
    input logic         mode,
    input logic         ie,
    input logic         ack,
    input logic         ev,
    input logic         flag,
    input logic         irq,
    input logic [1:0]   rd_addr,
    input logic [N-1:0] rd_data
);
    // R2
    no_disabled_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0 && !flag) |=> !flag);

    // R4
    flag_hold_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !ev) |=> !flag);

    // R5
    level_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && ev) |=> flag);

    // R7
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && ack && !ev) |=> !flag);

    // R6
    irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !irq);

    // R10
    ack_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 2'd0) |-> !rd_data[2]);

endmodule

bind kbi_ctrl kbi_ctrl_chk #(.N(N)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_q),
    .mode    (mode_q),
    .ie      (ie_q),
    .ack     (ack),
    .ev      (det_event),
    .flag    (ts_q.flag),
    .irq     (irq_out),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
);

// File: tb/tb_kbi_ctrl.sv
`timescale 1ns/1ps
module tb_kbi_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] key_in = '0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_out;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    kbi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .key_in(key_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_out(irq_out)
    );

    // behavioural reference: raw sample history, newest first
    logic [7:0] hq[$];
    logic [7:0] m_en, m_pol, m_chg;
    logic       m_mode, m_ie, m_flag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hq = {8'h00, 8'h00, 8'h00};
            m_en = 0; m_pol = 0; m_chg = 0;
            m_mode = 0; m_ie = 0; m_flag = 0;
        end else begin
            bit ev;
            bit ack;
            ev = 0;
            for (int i = 0; i < 8; i++) begin
                bit now_act, was_act;
                now_act = m_pol[i] ? hq[1][i] : !hq[1][i];
                was_act = m_pol[i] ? hq[2][i] : !hq[2][i];
                if (m_en[i]) begin
                    if (m_mode && now_act) ev = 1;
                    if (now_act && !was_act && !m_chg[i]) ev = 1;
                end
            end
            ack = wr_en && wr_addr == 2'd0 && wr_data[2];
            m_flag = ev || (m_flag && !ack);
            m_chg = 0;
            if (wr_en) begin
                if (wr_addr == 2'd0) begin m_mode = wr_data[0]; m_ie = wr_data[1]; end
                if (wr_addr == 2'd1) begin m_chg = m_en ^ wr_data; m_en = wr_data; end
                if (wr_addr == 2'd2) begin m_chg = m_pol ^ wr_data; m_pol = wr_data; end
            end
            hq.push_front(key_in);
            while (hq.size() > 3) void'(hq.pop_back());
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [7:0] exp_rd;
            case (rd_addr)
                2'd0: exp_rd = {4'b0, m_flag, 1'b0, m_ie, m_mode};
                2'd1: exp_rd = m_en;
                2'd2: exp_rd = m_pol;
                default: exp_rd = 8'h00;
            endcase
            total++;
            if (irq_out !== (m_flag & m_ie)) begin
                bad++;
                $display("FAIL R6 model irq act=%0b exp=%0b t=%0t", irq_out, m_flag & m_ie, $time);
            end
            total++;
            if (rd_data !== exp_rd) begin
                bad++;
                $display("FAIL R10 model rd_data act=%02h exp=%02h t=%0t", rd_data, exp_rd, $time);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) tick();
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%02h exp=%02h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
        rd_addr = a;
        #0.5;
        chk(tag, rd_data, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=<200000", cycles);
            finish_run();
        end
    end

    initial begin
        ticks(2);
        rst_n = 1'b1;
        tick();
        // R9 reset state
        rd_chk("R9 ctrl", 2'd0, 8'h00);
        rd_chk("R9 en", 2'd1, 8'h00);
        rd_chk("R9 pol", 2'd2, 8'h00);
        chk("R9 irq", {7'b0, irq_out}, 8'h00);

        wr(2'd2, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h02);
        rd_addr = 2'd0;
        // R1 latency, R3 rising, R6 irq
        key_in[0] = 1'b1;
        ticks(2);
        rd_chk("R1 not before third edge", 2'd0, 8'h02);
        tick();
        rd_chk("R1 set on third edge", 2'd0, 8'h0A);
        chk("R6 irq with enable", {7'b0, irq_out}, 8'h01);

        // R4 R7 clear in edge mode while held
        wr(2'd0, 8'h06);
        rd_chk("R7 ack clears, reads 0", 2'd0, 8'h02);
        ticks(3);
        rd_chk("R4 held level no re-set", 2'd0, 8'h02);

        // R5 level mode
        wr(2'd0, 8'h03);
        tick();
        rd_chk("R5 level sets", 2'd0, 8'h0B);
        wr(2'd0, 8'h07);
        rd_chk("R5 ack blocked while active", 2'd0, 8'h0B);
        key_in[0] = 1'b0;
        ticks(3);
        wr(2'd0, 8'h07);
        rd_chk("R5 ack after release", 2'd0, 8'h03);
        wr(2'd0, 8'h02);

        // R2 disabled pin
        key_in[5] = 1'b1; ticks(3);
        key_in[5] = 1'b0; ticks(3);
        rd_chk("R2 disabled pin", 2'd0, 8'h02);

        // R8 enabling an already-active falling pin
        wr(2'd1, 8'h09);
        ticks(3);
        rd_chk("R8 enable no false edge", 2'd0, 8'h02);
        // R3 falling sense
        key_in[3] = 1'b1; ticks(4);
        rd_chk("R3 rise on falling pin", 2'd0, 8'h02);
        key_in[3] = 1'b0; ticks(3);
        rd_chk("R3 falling sets", 2'd0, 8'h0A);
        wr(2'd0, 8'h06);
        rd_chk("R7 clear", 2'd0, 8'h02);

        // R8 sense toggle
        wr(2'd2, 8'h09);
        wr(2'd2, 8'h01);
        ticks(3);
        rd_chk("R8 sense change no edge", 2'd0, 8'h02);

        // R6 request enable off
        wr(2'd0, 8'h00);
        key_in[0] = 1'b1; ticks(3);
        rd_chk("R6 flag without enable", 2'd0, 8'h08);
        chk("R6 irq masked", {7'b0, irq_out}, 8'h00);
        wr(2'd0, 8'h04);
        rd_chk("R7 clear masked", 2'd0, 8'h00);

        // R7 clear on the detection edge
        key_in[0] = 1'b0; ticks(3);
        wr(2'd0, 8'h02);
        key_in[0] = 1'b1;
        ticks(2);
        wr(2'd0, 8'h06);
        rd_chk("R7 set wins over clear", 2'd0, 8'h0A);
        wr(2'd0, 8'h06);
        rd_chk("R7 later clear", 2'd0, 8'h02);

        // R10 map and read-only flag
        wr(2'd0, 8'h0A);
        rd_chk("R10 flag write ignored", 2'd0, 8'h02);
        rd_chk("R10 enable word", 2'd1, 8'h09);
        rd_chk("R10 sense word", 2'd2, 8'h01);
        rd_chk("R10 empty word", 2'd3, 8'h00);

        ticks(2);
        finish_run();
    end

endmodule